// File: doc/BRIEF.md
# Mode-Configurable Sum-of-Products Output Macrocell

This block is one output cell of a small sum-of-products logic device. An AND-array outside the block hands it a vector of product terms. The cell ORs these terms into a sum and drives the sum to its pad. The sum can go out directly with a chosen polarity, or it can go out inverted through a D flip-flop that the shared clock drives. The cell also sends one value back into the array. That value is the flip-flop state, the pin level, or a constant zero, depending on how the cell is set up.

Two static inputs set the cell's behaviour:
- A global mode: registered, complex or simple.
- A per-cell function: registered output, combinatorial output, or dedicated input.

Together they decide three things:
- whether one product term is taken out of the sum to serve as the output enable;
- whether the enable comes from the global enable pin, from that term, or is fixed on;
- where the feedback comes from.

A build-time position parameter marks a cell as ordinary, as one of the two outermost cells, or as one of the two center cells. Outermost and center cells carry extra restrictions in some modes. The pad is modelled as a data bit plus an enable bit; a deasserted enable means high impedance.

Top module: `sopMacrocell`

## Requirements
- R1: While the asynchronous reset `rst` is high, the flip-flop holds 0. In registered mode with the registered function, the pad data therefore reads 1 and the feedback reads 0 until the first clock edge after release.
- R2: On every rising clock edge outside reset, the flip-flop loads the OR of all NUM_PT product terms, in every mode. With mode 00 and function 00, the pad data is the inverted flip-flop state, the feedback is the true flip-flop state, and `activeHigh` has no effect.
- R3: With mode 00 and function 00, `padOe` follows `oeGlobal`.
- R4: With mode 00 and function 01:
  - `padOe` equals the highest-index product term.
  - The pad data is the OR of the other NUM_PT-1 terms, passed through unchanged when `activeHigh`=1 and inverted when it is 0.
  - The feedback equals `padIn`.
- R5: A function code of 10 or 11 makes the cell a dedicated input: `padOe`=0 and the feedback equals `padIn`. This holds in mode 00, in mode 01 for non-outermost cells, and in modes 10/11 for non-center cells.
- R6: In mode 01 (complex), every non-input cell behaves as described in R4, and that includes a cell with function 00. No flip-flop path is used and `oeGlobal` is ignored.
- R7: In mode 01, an outermost cell returns feedback 0. It ignores an input function code and always drives as in R6.
- R8: In mode 10 (simple), an output cell has `padOe`=1. Its pad data is the OR of all NUM_PT terms with polarity applied, and its feedback is `padIn`. `oeGlobal` is ignored.
- R9: In simple mode, a center cell is always an output (`padOe`=1) whatever its function code, and it returns feedback 0.
- R10: Mode code 11 behaves exactly as mode code 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Global clock for the flip-flop |
| rst | input | 1 | Asynchronous power-up reset, active high |
| mode | input | 2 | Global mode: 00 registered, 01 complex, 10/11 simple |
| cellFn | input | 2 | Cell function: 00 registered, 01 combinatorial, 10/11 input |
| activeHigh | input | 1 | Combinatorial polarity: 1 = true sum, 0 = inverted |
| ptIn | input | NUM_PT | Product terms from the AND-array |
| oeGlobal | input | 1 | Global output-enable pin, active high |
| padIn | input | 1 | Level seen on the pad |
| padOut | output | 1 | Data driven toward the pad |
| padOe | output | 1 | Pad driver enable; 0 means high impedance |
| fbOut | output | 1 | Feedback value returned to the AND-array |

## Verification
The bench goes after the following corner cases, each of which a wrong design would expose:
- **Flip-flop capture in other modes.** The flip-flop keeps loading while the cell sits in a combinatorial mode. A design that clocked only in registered mode would show a stale state on the first cycle back in mode 00.
- **Lost sum term.** When the top term is the only one active, a cell that borrows that term as its enable must drive a zero sum. A design that kept all eight terms in the sum would drive a one.
- **Position overrides.** An outermost cell in complex mode and a center cell in simple mode are both given an input function code. A design that obeyed the code would float the pad or leak the pin back as feedback.
- **Reset.** An asynchronous reset mid-run must clear the state at once. A design with a synchronous clear would keep the old bit until the next edge.

// File: rtl/sopMacrocellPkg.sv
package sopMacrocellPkg;

  typedef enum logic [1:0] {
    MODE_REG    = 2'b00,
    MODE_CPLX   = 2'b01,
    MODE_SIMP   = 2'b10,
    MODE_SIMP_B = 2'b11
  } macroMode_t;

  typedef enum logic [1:0] {
    POS_INNER  = 2'd0,
    POS_EDGE   = 2'd1,
    POS_CENTER = 2'd2
  } cellPos_t;

  // strobes from the control decode to the datapath
  typedef struct packed {
    logic selFullSum;
    logic regPath;
    logic oeFromPin;
    logic oeFromTerm;
    logic oeForceOn;
    logic fbFromReg;
    logic fbBlocked;
    logic invertOut;
  } mcStrobes_t;

endpackage

// File: rtl/sopMacrocellCtrl.sv
module sopMacrocellCtrl
  import sopMacrocellPkg::*;
#(
  parameter cellPos_t CELL_POS = POS_INNER
) (
  input  logic [1:0]  mode,
  input  logic [1:0]  cellFn,
  input  logic        activeHigh,
  output mcStrobes_t  strobes
);

  logic isReg;
  logic isCplx;
  logic isSimp;
  logic forceOut;
  logic cellIsInput;
  logic regPath;

  assign isReg  = (mode == MODE_REG);
  assign isCplx = (mode == MODE_CPLX);
  assign isSimp = mode[1];

  // position-dependent restrictions picked at build time
  generate
    if (CELL_POS == POS_EDGE) begin : g_edge
      assign forceOut = isCplx;
    end else if (CELL_POS == POS_CENTER) begin : g_center
      assign forceOut = isSimp;
    end else begin : g_inner
      assign forceOut = 1'b0;
    end
  endgenerate

  assign cellIsInput = cellFn[1] & ~forceOut;
  assign regPath     = isReg & (cellFn == 2'b00);

  always_comb begin
    strobes.selFullSum = isSimp | regPath;
    strobes.regPath    = regPath;
    strobes.oeFromPin  = regPath;
    strobes.oeFromTerm = ~isSimp & ~regPath & ~cellIsInput;
    strobes.oeForceOn  = isSimp & ~cellIsInput;
    strobes.fbFromReg  = regPath;
    strobes.fbBlocked  = forceOut;
    strobes.invertOut  = ~activeHigh;
  end

endmodule

// File: rtl/sopMacrocellDp.sv
module sopMacrocellDp
  import sopMacrocellPkg::*;
#(
  parameter int NUM_PT = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  mcStrobes_t        strobes,
  input  logic [NUM_PT-1:0] ptIn,
  input  logic              oeGlobal,
  input  logic              padIn,
  output logic              padOut,
  output logic              padOe,
  output logic              fbOut
);

  localparam int PART_W = NUM_PT - 1;

  logic              sumFull;
  logic              sumPart;
  logic              oeTerm;
  logic              sumSel;
  logic              combOut;
  logic              stateQ;
  logic [PART_W-1:0] partTerms;

  assign partTerms = ptIn[PART_W-1:0];
  assign oeTerm    = ptIn[NUM_PT-1];
  assign sumFull   = |ptIn;
  assign sumPart   = |partTerms;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) stateQ <= 1'b0;
    else     stateQ <= sumFull;
  end

  assign sumSel  = strobes.selFullSum ? sumFull : sumPart;
  assign combOut = sumSel ^ strobes.invertOut;

  always_comb begin
    padOut = strobes.regPath ? ~stateQ : combOut;

    if (strobes.oeFromPin)       padOe = oeGlobal;
    else if (strobes.oeFromTerm) padOe = oeTerm;
    else                         padOe = strobes.oeForceOn;

    if (strobes.fbBlocked)       fbOut = 1'b0;
    else if (strobes.fbFromReg)  fbOut = stateQ;
    else                         fbOut = padIn;
  end

endmodule

// File: rtl/sopMacrocell.sv
module sopMacrocell
  import sopMacrocellPkg::*;
#(
  parameter int       NUM_PT   = 8,
  parameter cellPos_t CELL_POS = POS_INNER
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic [1:0]        cellFn,
  input  logic              activeHigh,
  input  logic [NUM_PT-1:0] ptIn,
  input  logic              oeGlobal,
  input  logic              padIn,
  output logic              padOut,
  output logic              padOe,
  output logic              fbOut
);

  mcStrobes_t strobes;

  sopMacrocellCtrl #(.CELL_POS(CELL_POS)) ctrl_i (
    .mode       (mode),
    .cellFn     (cellFn),
    .activeHigh (activeHigh),
    .strobes    (strobes)
  );

  sopMacrocellDp #(.NUM_PT(NUM_PT)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .ptIn     (ptIn),
    .oeGlobal (oeGlobal),
    .padIn    (padIn),
    .padOut   (padOut),
    .padOe    (padOe),
    .fbOut    (fbOut)
  );

endmodule

// File: rtl/sopMacrocellChk.sv
module sopMacrocellChk
  import sopMacrocellPkg::*;
#(
  parameter int       NUM_PT   = 8,
  parameter cellPos_t CELL_POS = POS_INNER
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mode,
  input logic [1:0]        cellFn,
  input logic              activeHigh,
  input logic [NUM_PT-1:0] ptIn,
  input logic              oeGlobal,
  input logic              padIn,
  input logic              padOut,
  input logic              padOe,
  input logic              fbOut
);

  logic armed;
  logic regCell;
  logic combCell;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assign regCell  = (mode == 2'b00) && (cellFn == 2'b00);
  assign combCell = (mode == 2'b00) && (cellFn == 2'b01);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    (!armed && regCell) |-> (fbOut == 1'b0 && padOut == 1'b1)); // R1

  AST_REG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (armed && regCell) |-> (fbOut == $past(|ptIn))); // R2

  AST_REG_INVERT: assert property (@(posedge clk) disable iff (rst)
    regCell |-> (padOut == ~fbOut)); // R2

  AST_REG_OE: assert property (@(posedge clk) disable iff (rst)
    regCell |-> (padOe == oeGlobal)); // R3

  AST_COMB_OE: assert property (@(posedge clk) disable iff (rst)
    combCell |-> (padOe == ptIn[NUM_PT-1])); // R4

  AST_COMB_POLARITY: assert property (@(posedge clk) disable iff (rst)
    (combCell && activeHigh && ptIn[NUM_PT-2:0] == '0) |-> !padOut); // R4

  AST_INPUT_OFF: assert property (@(posedge clk) disable iff (rst)
    ((mode == 2'b00) && cellFn[1]) |-> (!padOe && fbOut == padIn)); // R5

  AST_EDGE_NO_FB: assert property (@(posedge clk) disable iff (rst)
    ((CELL_POS == POS_EDGE) && (mode == 2'b01)) |-> (fbOut == 1'b0)); // R7

  AST_CENTER_DRIVES: assert property (@(posedge clk) disable iff (rst)
    ((CELL_POS == POS_CENTER) && mode[1]) |-> (padOe && fbOut == 1'b0)); // R9

endmodule

bind sopMacrocell sopMacrocellChk #(.NUM_PT(NUM_PT), .CELL_POS(CELL_POS)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .mode       (mode),
  .cellFn     (cellFn),
  .activeHigh (activeHigh),
  .ptIn       (ptIn),
  .oeGlobal   (oeGlobal),
  .padIn      (padIn),
  .padOut     (padOut),
  .padOe      (padOe),
  .fbOut      (fbOut)
);

// File: tb/sopMacrocell_tb_top.sv
`timescale 1ns/1ps
module sopMacrocell_tb_top;
  import sopMacrocellPkg::*;

  localparam int NUM_PT = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        mode = 2'b00;
  logic [1:0]        cellFn = 2'b00;
  logic              activeHigh = 1'b1;
  logic [NUM_PT-1:0] ptIn = '0;
  logic              oeGlobal = 1'b0;
  logic              padIn = 1'b0;
  logic [2:0]        padOut;
  logic [2:0]        padOe;
  logic [2:0]        fbOut;

  int  checkCount = 0;
  int  failCount  = 0;
  logic qExp = 1'b0;
  bit  finished = 1'b0;

  always #5 clk = ~clk;

  sopMacrocell #(.NUM_PT(NUM_PT), .CELL_POS(POS_INNER)) dut_i (
    .clk(clk), .rst(rst), .mode(mode), .cellFn(cellFn), .activeHigh(activeHigh),
    .ptIn(ptIn), .oeGlobal(oeGlobal), .padIn(padIn),
    .padOut(padOut[0]), .padOe(padOe[0]), .fbOut(fbOut[0]));

  sopMacrocell #(.NUM_PT(NUM_PT), .CELL_POS(POS_EDGE)) dutEdge_i (
    .clk(clk), .rst(rst), .mode(mode), .cellFn(cellFn), .activeHigh(activeHigh),
    .ptIn(ptIn), .oeGlobal(oeGlobal), .padIn(padIn),
    .padOut(padOut[1]), .padOe(padOe[1]), .fbOut(fbOut[1]));

  sopMacrocell #(.NUM_PT(NUM_PT), .CELL_POS(POS_CENTER)) dutCtr_i (
    .clk(clk), .rst(rst), .mode(mode), .cellFn(cellFn), .activeHigh(activeHigh),
    .ptIn(ptIn), .oeGlobal(oeGlobal), .padIn(padIn),
    .padOut(padOut[2]), .padOe(padOe[2]), .fbOut(fbOut[2]));

  // expected {oe, out, fb} for a cell at position pos (0 inner, 1 edge, 2 center)
  function automatic logic [2:0] expect3(int pos, logic q);
    logic oe, out, fb, part, full;
    part = |ptIn[NUM_PT-2:0];
    full = |ptIn;
    oe = 1'b0; out = 1'b0; fb = padIn;
    if (mode == 2'b00) begin
      if (cellFn == 2'b00) begin
        oe = oeGlobal; out = ~q; fb = q;
      end else if (cellFn == 2'b01) begin
        oe = ptIn[NUM_PT-1]; out = activeHigh ? part : ~part;
      end
    end else if (mode == 2'b01) begin
      if (pos == 1 || !cellFn[1]) begin
        oe = ptIn[NUM_PT-1]; out = activeHigh ? part : ~part;
      end
      if (pos == 1) fb = 1'b0;
    end else begin
      if (pos == 2 || !cellFn[1]) begin
        oe = 1'b1; out = activeHigh ? full : ~full;
      end
      if (pos == 2) fb = 1'b0;
    end
    return {oe, out, fb};
  endfunction

  function automatic string tagFor(int pos);
    if (mode == 2'b11) return "R10";
    if (mode == 2'b00) begin
      if (cellFn == 2'b00) return "R2";
      if (cellFn == 2'b01) return "R4";
      return "R5";
    end
    if (mode == 2'b01) begin
      if (pos == 1) return "R7";
      return cellFn[1] ? "R5" : "R6";
    end
    if (pos == 2) return "R9";
    return cellFn[1] ? "R5" : "R8";
  endfunction

  task automatic checkBit(string tag, string what, int inst, logic got, logic exp);
    checkCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s cell%0d %s: actual %b expected %b", tag, inst, what, got, exp);
    end
  endtask

  task automatic checkAll(string forceTag);
    for (int i = 0; i < 3; i++) begin
      logic [2:0] e;
      string t;
      e = expect3(i, qExp);
      t = (forceTag != "") ? forceTag : tagFor(i);
      checkBit((mode == 2'b00 && cellFn == 2'b00 && forceTag == "") ? "R3" : t,
               "oe", i, padOe[i], e[2]);
      if (e[2]) checkBit(t, "out", i, padOut[i], e[1]);
      checkBit(t, "fb", i, fbOut[i], e[0]);
    end
  endtask

  task automatic runStep(logic [1:0] m, logic [1:0] f, logic pol,
                         logic [NUM_PT-1:0] pt, logic oeg, logic pin, string tag);
    @(negedge clk);
    mode = m; cellFn = f; activeHigh = pol; ptIn = pt; oeGlobal = oeg; padIn = pin;
    #1;
    checkAll(tag);
    @(posedge clk);
    qExp = |pt;
  endtask

  function automatic logic [NUM_PT-1:0] pickTerms(int unsigned r);
    case (r % 5)
      0: return '0;
      1: return NUM_PT'(1) << ($urandom % NUM_PT);
      2: return NUM_PT'(1) << (NUM_PT - 1);
      3: return NUM_PT'($urandom & $urandom);
      default: return NUM_PT'($urandom);
    endcase
  endfunction

  initial begin
    void'($urandom(32'd20240611));
    // R1: state held at 0 during reset, registered pad reads high
    mode = 2'b00; cellFn = 2'b00; oeGlobal = 1'b1; ptIn = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    qExp = 1'b0;
    checkAll("R1");
    rst = 1'b0;
    #1;
    checkAll("R1");
    @(posedge clk); qExp = |ptIn;

    // R2: capture then observe; register keeps loading in other modes
    runStep(2'b00, 2'b00, 1'b0, 8'h00, 1'b1, 1'b1, "R2");
    runStep(2'b00, 2'b00, 1'b1, 8'h10, 1'b0, 1'b0, "R2");
    runStep(2'b01, 2'b01, 1'b1, 8'h01, 1'b1, 1'b0, "R2");
    runStep(2'b00, 2'b00, 1'b1, 8'h00, 1'b1, 1'b0, "R2");
    // R4/R6: only the enable term set -> sum must be zero
    runStep(2'b00, 2'b01, 1'b1, 8'h80, 1'b0, 1'b1, "R4");
    runStep(2'b00, 2'b01, 1'b0, 8'h80, 1'b0, 1'b1, "R4");
    runStep(2'b01, 2'b00, 1'b1, 8'h80, 1'b0, 1'b1, "R6");
    // R7/R9: position overrides an input code
    runStep(2'b01, 2'b10, 1'b1, 8'h82, 1'b0, 1'b1, "");
    runStep(2'b10, 2'b11, 1'b0, 8'h00, 1'b0, 1'b1, "");
    // R10: code 11 behaves like 10
    runStep(2'b11, 2'b01, 1'b1, 8'h80, 1'b0, 1'b1, "R10");
    runStep(2'b11, 2'b10, 1'b1, 8'h80, 1'b1, 1'b1, "R10");

    for (int n = 0; n < 3000; n++) begin
      runStep(2'($urandom), 2'($urandom), 1'($urandom), pickTerms($urandom),
              1'($urandom), 1'($urandom), "");
    end

    // R1: asynchronous reset mid-run clears the state at once
    runStep(2'b00, 2'b00, 1'b1, 8'h04, 1'b1, 1'b0, "R2");
    @(negedge clk);
    rst = 1'b1;
    #1;
    qExp = 1'b0;
    checkAll("R1");
    @(negedge clk);
    rst = 1'b0;
    #1;
    checkAll("R1");
    @(posedge clk); qExp = |ptIn;
    runStep(2'b00, 2'b00, 1'b1, 8'h00, 1'b1, 1'b0, "R2");

    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1'b1;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule